// File: doc/BRIEF.md
# Two-Phase Coarse/Fine Ramp Conversion Sequencer

This block is the digital half of a column-parallel ramp converter. A single shared step counter drives the analog ramp generator. The sequencer exposes that count and two phase indicators. Each column sees only one comparator bit, which is high once the active ramp has reached that column's input. A conversion has two phases. In the coarse phase every column watches one common coarse ramp, and each column keeps the count at which its comparator first rose. That coarse code then drives the column's ramp-select output, which picks one of 2^P fine ramps. All of these fine ramps sweep together in a much shorter fine phase.

Adjacent fine ramps are stretched by an overlap of K steps below and above their nominal span. A coarse decision that is one step off near a range boundary therefore still lands on a ramp that crosses the input. Each column merges its coarse and fine codes into one N-bit code, with N = P + Q, and removes the overlap offset. It clamps the result to the output range. The merged codes of all columns appear on one parallel bus while the done flag is high.

Comparator inputs are asynchronous to the block clock. The sequencer resynchronises them through S flops and delays its own count and phase windows by the same depth. Each latched count therefore belongs to the ramp step that made the comparator flip.

Top module: `dual_ramp_seq`

## Requirements
- R1: While and right after rst_ni is low, done_o, coarse_ramp_o and fine_ramp_o are low and every field of sel_o and of result_o reads 0.
- R2: When start_i is accepted, coarse_ramp_o is high for exactly 2^P consecutive cycles while ramp_step_o counts 0, 1, … 2^P−1. A column's coarse code is the ramp_step_o value of the cycle in which its cmp_i was first high.
- R3: Field j of sel_o (bits j·P upward, P bits wide) carries column j's coarse code before the fine ramp starts, and it stays unchanged until the next accepted start.
- R4: One settle cycle follows the coarse phase. Then fine_ramp_o is high for exactly 2^Q+2K consecutive cycles while ramp_step_o counts from 0 to 2^Q+2K−1. A column's fine code is the step of the cycle in which its cmp_i was first high in this phase.
- R5: Field j of result_o (bits j·N upward, N bits wide) equals coarse·2^Q + fine − K for column j.
- R6: If a comparator threshold offset of ±1 LSB moves a coarse decision by one step at a coarse range boundary, result_o still equals the true input code.
- R7: A column whose cmp_i never rises within a phase stores that phase's maximum code: 2^P−1 for coarse, 2^Q+2K−1 for fine.
- R8: Only the first high of cmp_i within a phase is taken. Later falls and rises of cmp_i in the same phase leave the stored code unchanged.
- R9: done_o rises on the (2^P+2^Q+2K+2S+2)-th rising edge, where the edge that accepts start_i counts as the first. done_o and result_o then hold until a new start_i. start_i is ignored from acceptance until done_o is high.
- R10: A merged value below 0 reads as 0, and one above 2^N−1 reads as 2^N−1.
- R11: coarse_ramp_o and fine_ramp_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, also the ramp step clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a conversion when idle or done |
| cmp_i | input | N_COLS | Per-column comparator, high once the ramp has reached the input |
| coarse_ramp_o | output | 1 | Coarse ramp must sweep this cycle |
| fine_ramp_o | output | 1 | All fine ramps must sweep this cycle |
| ramp_step_o | output | STEP_W | Current ramp step for the ramp generator |
| sel_o | output | N_COLS·P | Per-column fine ramp select |
| done_o | output | 1 | Results valid |
| result_o | output | N_COLS·N | Per-column merged code |

## Verification
The hardest case to reach from the ports is a coarse decision that is off by one step right at a coarse range boundary. The column then sweeps a neighbouring fine ramp, and only the overlap region recovers the correct code. The bench comparator model compares the ramp position against a per-column threshold that can be shifted by +1 or −1 LSB in the coarse phase only. Inputs are placed one LSB on either side of multiples of 2^Q, so the coarse code really lands on the wrong range. The expected merged value is still the unshifted input. Stuck-low, stuck-high and bouncing comparator patterns reach the no-trip, clamp and first-edge paths.

// File: rtl/drs_pkg.sv
package drs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COARSE,
    ST_SETTLE,
    ST_FINE,
    ST_DONE
  } seq_state_e;

  function automatic int drs_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/drs_sync.sv
module drs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];

endmodule

// File: rtl/drs_ctrl.sv
module drs_ctrl import drs_pkg::*; #(
  parameter int P_BITS = 3,
  parameter int Q_BITS = 5,
  parameter int OVL    = 2,
  parameter int LAT    = 2,
  parameter int STEP_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              coarse_ramp_o,
  output logic              fine_ramp_o,
  output logic [STEP_W-1:0] step_o,
  output logic              done_o,
  output logic              clear_o,
  output logic              win_c_o,
  output logic              win_f_o,
  output logic              end_c_o,
  output logic              end_f_o,
  output logic [STEP_W-1:0] cnt_o
);

  localparam int C_STEPS = 1 << P_BITS;
  localparam int F_STEPS = (1 << Q_BITS) + 2 * OVL;
  // each phase runs LAT extra cycles so delayed comparator samples drain
  localparam int C_LAST  = C_STEPS + LAT - 1;
  localparam int F_LAST  = F_STEPS + LAT - 1;
  localparam int TW      = $clog2(drs_max(C_LAST, F_LAST) + 1);

  seq_state_e state_q, state_d;
  logic [TW-1:0] tick_q, tick_d;

  always_comb begin
    state_d = state_q;
    tick_d  = tick_q;
    clear_o = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          state_d = ST_COARSE;
          tick_d  = '0;
          clear_o = 1'b1;
        end
      end
      ST_COARSE: begin
        if (tick_q == TW'(C_LAST)) begin
          state_d = ST_SETTLE;
          tick_d  = '0;
        end else begin
          tick_d = tick_q + 1'b1;
        end
      end
      ST_SETTLE: begin
        state_d = ST_FINE;
        tick_d  = '0;
      end
      ST_FINE: begin
        if (tick_q == TW'(F_LAST)) begin
          state_d = ST_DONE;
          tick_d  = '0;
        end else begin
          tick_d = tick_q + 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        tick_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tick_q  <= '0;
    end else begin
      state_q <= state_d;
      tick_q  <= tick_d;
    end
  end

  assign coarse_ramp_o = (state_q == ST_COARSE) && (tick_q < TW'(C_STEPS));
  assign fine_ramp_o   = (state_q == ST_FINE)   && (tick_q < TW'(F_STEPS));
  assign step_o        = STEP_W'(tick_q);
  assign done_o        = (state_q == ST_DONE);
  assign end_c_o       = (state_q == ST_COARSE) && (tick_q == TW'(C_LAST));
  assign end_f_o       = (state_q == ST_FINE)   && (tick_q == TW'(F_LAST));

  // align step and phase window with the synchronizer depth
  logic [LAT-1:0]    wc_q, wf_q;
  logic [STEP_W-1:0] cnt_q [LAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wc_q <= '0;
      wf_q <= '0;
      for (int i = 0; i < LAT; i++) cnt_q[i] <= '0;
    end else begin
      wc_q     <= {wc_q[LAT-2:0], coarse_ramp_o};
      wf_q     <= {wf_q[LAT-2:0], fine_ramp_o};
      cnt_q[0] <= step_o;
      for (int i = 1; i < LAT; i++) cnt_q[i] <= cnt_q[i-1];
    end
  end

  assign win_c_o = wc_q[LAT-1];
  assign win_f_o = wf_q[LAT-1];
  assign cnt_o   = cnt_q[LAT-1];

endmodule

// File: rtl/drs_merge.sv
module drs_merge #(
  parameter int P_BITS = 3,
  parameter int Q_BITS = 5,
  parameter int OVL    = 2,
  parameter int FW     = 6
) (
  input  logic [P_BITS-1:0]        coarse_i,
  input  logic [FW-1:0]            fine_i,
  output logic [P_BITS+Q_BITS-1:0] result_o
);

  localparam int N_BITS = P_BITS + Q_BITS;
  localparam int MAXV   = (1 << N_BITS) - 1;

  int sum;

  always_comb begin
    sum = int'(coarse_i) * (1 << Q_BITS) + int'(fine_i) - OVL;
    if (sum < 0)         result_o = '0;
    else if (sum > MAXV) result_o = N_BITS'(MAXV);
    else                 result_o = N_BITS'(sum);
  end

endmodule

// File: rtl/drs_column.sv
module drs_column #(
  parameter int P_BITS = 3,
  parameter int Q_BITS = 5,
  parameter int OVL    = 2,
  parameter int LAT    = 2,
  parameter int STEP_W = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cmp_i,
  input  logic                     clear_i,
  input  logic                     win_c_i,
  input  logic                     win_f_i,
  input  logic                     end_c_i,
  input  logic                     end_f_i,
  input  logic [STEP_W-1:0]        cnt_i,
  output logic [P_BITS-1:0]        sel_o,
  output logic [P_BITS+Q_BITS-1:0] result_o
);

  localparam int C_MAX = (1 << P_BITS) - 1;
  localparam int F_MAX = (1 << Q_BITS) + 2 * OVL - 1;
  localparam int FW    = $clog2(F_MAX + 1);

  logic              cmp_s;
  logic              tc_q, tf_q;
  logic [P_BITS-1:0] coarse_q;
  logic [FW-1:0]     fine_q;

  drs_sync #(.STAGES(LAT)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_i),
    .q_o   (cmp_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tc_q     <= 1'b0;
      tf_q     <= 1'b0;
      coarse_q <= '0;
      fine_q   <= '0;
    end else if (clear_i) begin
      tc_q <= 1'b0;
      tf_q <= 1'b0;
    end else begin
      // first high wins; at window end without a trip take the phase maximum
      if (!tc_q && win_c_i && (cmp_s || end_c_i)) begin
        tc_q     <= 1'b1;
        coarse_q <= cmp_s ? P_BITS'(cnt_i) : P_BITS'(C_MAX);
      end
      if (!tf_q && win_f_i && (cmp_s || end_f_i)) begin
        tf_q   <= 1'b1;
        fine_q <= cmp_s ? FW'(cnt_i) : FW'(F_MAX);
      end
    end
  end

  assign sel_o = coarse_q;

  drs_merge #(
    .P_BITS(P_BITS),
    .Q_BITS(Q_BITS),
    .OVL   (OVL),
    .FW    (FW)
  ) u_merge (
    .coarse_i(coarse_q),
    .fine_i  (fine_q),
    .result_o(result_o)
  );

endmodule

// File: rtl/dual_ramp_seq.sv
module dual_ramp_seq import drs_pkg::*; #(
  parameter int N_COLS      = 4,
  parameter int P_BITS      = 3,
  parameter int Q_BITS      = 5,
  parameter int OVL         = 2,
  parameter int SYNC_STAGES = 2,
  localparam int N_BITS     = P_BITS + Q_BITS,
  localparam int STEP_W     = drs_max($clog2((1 << Q_BITS) + 2 * OVL), P_BITS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [N_COLS-1:0]        cmp_i,
  output logic                     coarse_ramp_o,
  output logic                     fine_ramp_o,
  output logic [STEP_W-1:0]        ramp_step_o,
  output logic [N_COLS*P_BITS-1:0] sel_o,
  output logic                     done_o,
  output logic [N_COLS*N_BITS-1:0] result_o
);

  logic              clear;
  logic              win_c, win_f, end_c, end_f;
  logic [STEP_W-1:0] cnt_d;

  drs_ctrl #(
    .P_BITS(P_BITS),
    .Q_BITS(Q_BITS),
    .OVL   (OVL),
    .LAT   (SYNC_STAGES),
    .STEP_W(STEP_W)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .coarse_ramp_o(coarse_ramp_o),
    .fine_ramp_o  (fine_ramp_o),
    .step_o       (ramp_step_o),
    .done_o       (done_o),
    .clear_o      (clear),
    .win_c_o      (win_c),
    .win_f_o      (win_f),
    .end_c_o      (end_c),
    .end_f_o      (end_f),
    .cnt_o        (cnt_d)
  );

  for (genvar j = 0; j < N_COLS; j++) begin : g_col
    drs_column #(
      .P_BITS(P_BITS),
      .Q_BITS(Q_BITS),
      .OVL   (OVL),
      .LAT   (SYNC_STAGES),
      .STEP_W(STEP_W)
    ) u_col (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cmp_i   (cmp_i[j]),
      .clear_i (clear),
      .win_c_i (win_c),
      .win_f_i (win_f),
      .end_c_i (end_c),
      .end_f_i (end_f),
      .cnt_i   (cnt_d),
      .sel_o   (sel_o[j*P_BITS +: P_BITS]),
      .result_o(result_o[j*N_BITS +: N_BITS])
    );
  end

endmodule

// File: rtl/drs_checker.sv
module drs_checker #(
  parameter int N_COLS = 4,
  parameter int P_BITS = 3,
  parameter int Q_BITS = 5,
  parameter int OVL    = 2,
  parameter int STEP_W = 6,
  parameter int N_BITS = 8
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     start_i,
  input logic                     coarse_ramp_o,
  input logic                     fine_ramp_o,
  input logic [STEP_W-1:0]        ramp_step_o,
  input logic [N_COLS*P_BITS-1:0] sel_o,
  input logic                     done_o,
  input logic [N_COLS*N_BITS-1:0] result_o
);

  localparam int C_STEPS = 1 << P_BITS;
  localparam int F_STEPS = (1 << Q_BITS) + 2 * OVL;

  AST_PHASE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(coarse_ramp_o && fine_ramp_o)); // R11

  AST_COARSE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coarse_ramp_o |-> (ramp_step_o < C_STEPS)); // R2

  AST_COARSE_FROM_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(coarse_ramp_o) |-> (ramp_step_o == '0)); // R2

  AST_STEP_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coarse_ramp_o && $past(coarse_ramp_o)) |-> (ramp_step_o == STEP_W'($past(ramp_step_o) + 1))); // R2

  AST_FINE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fine_ramp_o |-> (ramp_step_o < F_STEPS)); // R4

  AST_SEL_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fine_ramp_o |-> $stable(sel_o)); // R3

  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o); // R9

  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> $stable(result_o)); // R9

  AST_BUSY_NOT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coarse_ramp_o || fine_ramp_o) |-> !done_o); // R9

endmodule

bind dual_ramp_seq drs_checker #(
  .N_COLS(N_COLS),
  .P_BITS(P_BITS),
  .Q_BITS(Q_BITS),
  .OVL   (OVL),
  .STEP_W(STEP_W),
  .N_BITS(N_BITS)
) u_drs_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .coarse_ramp_o(coarse_ramp_o),
  .fine_ramp_o  (fine_ramp_o),
  .ramp_step_o  (ramp_step_o),
  .sel_o        (sel_o),
  .done_o       (done_o),
  .result_o     (result_o)
);

// File: tb/dual_ramp_seq_bench.sv
`timescale 1ns/1ps
module dual_ramp_seq_bench;

  localparam int N_COLS  = 4;
  localparam int P_BITS  = 3;
  localparam int Q_BITS  = 5;
  localparam int OVL     = 2;
  localparam int SYNC    = 2;
  localparam int N_BITS  = P_BITS + Q_BITS;
  localparam int STEP_W  = 6;
  localparam int FS      = 1 << Q_BITS;
  localparam int C_STEPS = 1 << P_BITS;
  localparam int F_STEPS = FS + 2 * OVL;
  localparam int MAXV    = (1 << N_BITS) - 1;
  localparam int LATENCY = C_STEPS + FS + 2 * OVL + 2 * SYNC + 2;

  logic                     clk_i = 1'b0;
  logic                     rst_ni = 1'b0;
  logic                     start_i = 1'b0;
  logic [N_COLS-1:0]        cmp_i;
  logic                     coarse_ramp_o, fine_ramp_o, done_o;
  logic [STEP_W-1:0]        ramp_step_o;
  logic [N_COLS*P_BITS-1:0] sel_o;
  logic [N_COLS*N_BITS-1:0] result_o;

  always #2.5 clk_i = ~clk_i;

  dual_ramp_seq #(
    .N_COLS(N_COLS), .P_BITS(P_BITS), .Q_BITS(Q_BITS), .OVL(OVL), .SYNC_STAGES(SYNC)
  ) u_dual_ramp_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .cmp_i(cmp_i),
    .coarse_ramp_o(coarse_ramp_o), .fine_ramp_o(fine_ramp_o), .ramp_step_o(ramp_step_o),
    .sel_o(sel_o), .done_o(done_o), .result_o(result_o)
  );

  int checks = 0;
  int errors = 0;

  // per-column input level, coarse threshold shift, comparator mode
  // mode 0 normal, 1 fine never trips, 2 fine always high, 3 bouncing, 4 coarse never trips
  int x_a [N_COLS];
  int e_a [N_COLS];
  int m_a [N_COLS];

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic bit lvl(input bit fine, input int step, input int sel,
                             input int x, input int e, input int m);
    if (step < 0) return 1'b0;
    if (!fine) begin
      if (m == 4) return 1'b0;
      return ((step + 1) * FS + e) > x;
    end
    if (m == 1) return 1'b0;
    if (m == 2) return 1'b1;
    return (sel * FS - OVL + step) >= x;
  endfunction

  function automatic bit cmp_of(input bit fine, input int step, input int sel,
                                input int x, input int e, input int m);
    bit now;
    now = lvl(fine, step, sel, x, e, m);
    if (m != 3) return now;
    return now && (!lvl(fine, step - 1, sel, x, e, m) || ((step >> 1) & 1) == 1);
  endfunction

  always_comb begin
    for (int j = 0; j < N_COLS; j++) begin
      if (coarse_ramp_o)
        cmp_i[j] = cmp_of(1'b0, int'(ramp_step_o), 0, x_a[j], e_a[j], m_a[j]);
      else if (fine_ramp_o)
        cmp_i[j] = cmp_of(1'b1, int'(ramp_step_o), int'(sel_o[j*P_BITS +: P_BITS]),
                          x_a[j], e_a[j], m_a[j]);
      else
        cmp_i[j] = 1'b0;
    end
  end

  function automatic int exp_coarse(input int j);
    for (int c = 0; c < C_STEPS; c++)
      if (lvl(1'b0, c, 0, x_a[j], e_a[j], m_a[j])) return c;
    return C_STEPS - 1;
  endfunction

  function automatic int exp_fine(input int j, input int c);
    for (int t = 0; t < F_STEPS; t++)
      if (lvl(1'b1, t, c, x_a[j], e_a[j], m_a[j])) return t;
    return F_STEPS - 1;
  endfunction

  typedef struct packed {
    logic [N_COLS*N_BITS-1:0] res;
    logic [N_COLS*P_BITS-1:0] sel;
  } exp_t;

  exp_t  exp_q [$];
  string tag_q [$];

  int lat = 0;
  bit tracking = 1'b0;
  bit done_prev = 1'b0;
  bit both_seen = 1'b0;
  int c_len = 0, f_len = 0, f_top = 0;

  always @(posedge clk_i) if (tracking) lat++;

  // monitor: pops the expected item when done rises
  always @(negedge clk_i) begin
    if (coarse_ramp_o && fine_ramp_o) both_seen = 1'b1;
    if (coarse_ramp_o) c_len++;
    if (fine_ramp_o) begin
      f_len++;
      f_top = int'(ramp_step_o);
    end
    if (done_o && !done_prev) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9", "done without conversion", 1, 0);
      end else begin
        exp_t  it;
        string rq;
        it = exp_q.pop_front();
        rq = tag_q.pop_front();
        chk(lat == LATENCY, "R9", "done latency", lat, LATENCY);
        chk(c_len == C_STEPS, "R2", "coarse ramp cycles", c_len, C_STEPS);
        chk(f_len == F_STEPS, "R4", "fine ramp cycles", f_len, F_STEPS);
        chk(f_top == F_STEPS - 1, "R4", "last fine step", f_top, F_STEPS - 1);
        for (int j = 0; j < N_COLS; j++) begin
          chk(sel_o[j*P_BITS +: P_BITS] == it.sel[j*P_BITS +: P_BITS], "R3",
              $sformatf("%s col%0d select", rq, j),
              sel_o[j*P_BITS +: P_BITS], it.sel[j*P_BITS +: P_BITS]);
          chk(result_o[j*N_BITS +: N_BITS] == it.res[j*N_BITS +: N_BITS], rq,
              $sformatf("col%0d result", j),
              result_o[j*N_BITS +: N_BITS], it.res[j*N_BITS +: N_BITS]);
        end
      end
      tracking = 1'b0;
      c_len = 0;
      f_len = 0;
      f_top = 0;
    end
    done_prev = done_o;
  end

  task automatic conv(input string rq, input bit linear, input bit poke);
    exp_t it;
    for (int j = 0; j < N_COLS; j++) begin
      int c, f, r;
      c = exp_coarse(j);
      f = exp_fine(j, c);
      r = c * FS + f - OVL;
      if (r < 0) r = 0;
      if (r > MAXV) r = MAXV;
      if (linear) r = x_a[j];
      it.res[j*N_BITS +: N_BITS] = N_BITS'(r);
      it.sel[j*P_BITS +: P_BITS] = P_BITS'(c);
    end
    exp_q.push_back(it);
    tag_q.push_back(rq);
    @(negedge clk_i);
    start_i = 1'b1;
    lat = 0;
    tracking = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (poke) begin
      // R9: start pulses while busy must not restart the conversion
      repeat (5) @(negedge clk_i);
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      repeat (20) @(negedge clk_i);
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk_i);
    repeat (6) @(negedge clk_i);
    chk(done_o == 1'b1, "R9", "done held", done_o, 1);
    chk(result_o == it.res, "R9", "result held", result_o, it.res);
  endtask

  task automatic set_col(input int j, input int x, input int e, input int m);
    x_a[j] = x;
    e_a[j] = e;
    m_a[j] = m;
  endtask

  initial begin
    for (int j = 0; j < N_COLS; j++) set_col(j, 0, 0, 0);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R1", "done at reset", done_o, 0);
    chk(coarse_ramp_o == 1'b0 && fine_ramp_o == 1'b0, "R1", "ramps at reset",
        {coarse_ramp_o, fine_ramp_o}, 0);
    chk(sel_o == '0, "R1", "select at reset", sel_o, 0);
    chk(result_o == '0, "R1", "result at reset", result_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(done_o == 1'b0 && result_o == '0, "R1", "idle after reset", result_o, 0);

    // R2 R5: plain codes across the range
    set_col(0, 0, 0, 0);   set_col(1, 37, 0, 0);
    set_col(2, 128, 0, 0); set_col(3, 255, 0, 0);
    conv("R5", 1'b1, 1'b0);

    // R6: coarse decision pushed across a range boundary
    set_col(0, 32, 1, 0);  set_col(1, 63, -1, 0);
    set_col(2, 96, 1, 0);  set_col(3, 191, -1, 0);
    conv("R6", 1'b1, 1'b0);

    // R7 R10: missing trips and clamping
    set_col(0, 40, 0, 1);  set_col(1, 20, 0, 4);
    set_col(2, 5, 0, 2);   set_col(3, 255, 0, 1);
    conv("R7", 1'b0, 1'b0);
    chk(result_o[2*N_BITS +: N_BITS] == 0, "R10", "clamp low", result_o[2*N_BITS +: N_BITS], 0);
    chk(result_o[3*N_BITS +: N_BITS] == MAXV, "R10", "clamp high",
        result_o[3*N_BITS +: N_BITS], MAXV);
    chk(result_o[1*N_BITS +: N_BITS] == (C_STEPS - 1) * FS - OVL, "R7", "coarse max used",
        result_o[1*N_BITS +: N_BITS], (C_STEPS - 1) * FS - OVL);

    // R8 R9: bouncing comparators plus start pulses while busy
    set_col(0, 17, 0, 3);  set_col(1, 100, 0, 3);
    set_col(2, 160, 0, 3); set_col(3, 250, 0, 3);
    conv("R8", 1'b1, 1'b1);

    // R5 R6: sweep with mixed threshold shifts
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < N_COLS; j++)
        set_col(j, (i * 53 + j * 29 + 7) % (MAXV + 1), ((i + j) % 3) - 1, 0);
      conv("R6", 1'b1, 1'b0);
    end

    chk(!both_seen, "R11", "ramps overlapped", both_seen, 0);
    chk(exp_q.size() == 0, "R9", "pending conversions", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL R9 watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule